// File: doc/BRIEF.md
# Fault-Counter Configuration Register Block for a CAN Node

This block holds the configuration control register of a CAN node together with its receive and transmit fault counters. A host-side register port reads and writes the control register and a transmit-fault register. A strobe port lets the protocol engine step or clear the counters. Bit 0 of the control register is the configuration-hold bit. While it is set, the protocol engine is disabled and the transmit line is driven to the recessive level. This lets software change settings safely.

While the hold bit is set, a single write to the transmit-fault register loads that value into both counters at once. Engine strobes are ignored in that mode. When hold is cleared, the engine is enabled on the next clock and the counters follow the strobes again. The counters saturate at both ends. After a reset the control register holds 0x07, so the node starts in hold with both counters at zero.

Top module: `can_cfg_regs`

## Requirements
- R1: During and after reset, with no writes yet, address 0 reads 0x07 and addresses 1, 2 and 3 read 0x00. Both counters are 0, `eng_en` is 0 and `tx_force_rec` is 1.
- R2: After the clock edge that writes address 0, `eng_en` equals the inverse of the written bit 0 and `tx_force_rec` equals bit 0.
- R3: Address 0 stores all 8 written bits and reads them back unchanged.
- R4: Setting bit 0 of the control register does not change either counter.
- R5: While bit 0 is 1, a write to address 1 loads the written byte into both the receive and the transmit counter on that clock edge.
- R6: While bit 0 is 0, a write to address 1 has no effect on either counter.
- R7: While bit 0 is 1, the strobes `rx_inc`, `rx_dec`, `tx_inc`, `tx_dec` and `cnt_clr` have no effect.
- R8: While bit 0 is 0, each counter steps up by one on its inc strobe and down by one on its dec strobe. It stays at 255 when incremented and at 0 when decremented. If inc and dec are both asserted, the counter is unchanged.
- R9: While bit 0 is 0, `cnt_clr` clears both counters to 0. It takes precedence over the inc and dec strobes.
- R10: The read data is combinational from `reg_addr`: 0 gives the control register, 1 the transmit counter, 2 the receive counter and 3 gives 0x00.
- R11: In a cycle where address 0 is written, strobe gating uses bit 0 as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| rx_inc | input | 1 | Receive counter increment |
| rx_dec | input | 1 | Receive counter decrement |
| tx_inc | input | 1 | Transmit counter increment |
| tx_dec | input | 1 | Transmit counter decrement |
| cnt_clr | input | 1 | Clear both counters |
| eng_en | output | 1 | Protocol engine enable |
| tx_force_rec | output | 1 | Force transmit line recessive |
| rx_err_cnt | output | 8 | Receive fault counter |
| tx_err_cnt | output | 8 | Transmit fault counter |

## Verification
The main collision is a host write to the control register in the same cycle as engine strobes. The other is a counter load arriving together with strobes. The bench provokes both with directed cycles: one clears hold while `tx_inc` is high, and another loads the counters while every strobe is active. Random cycles then mix writes and strobes freely. A bench model that gates strobes on the pre-write hold bit judges each outcome, comparing every output after every edge.

// File: rtl/can_cfg_regs.sv
module can_cfg_regs #(
  parameter int W = 8,
  parameter int AW = 2,
  parameter logic [W-1:0] CTRL_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          rx_inc,
  input  logic          rx_dec,
  input  logic          tx_inc,
  input  logic          tx_dec,
  input  logic          cnt_clr,
  output logic          eng_en,
  output logic          tx_force_rec,
  output logic [W-1:0]  rx_err_cnt,
  output logic [W-1:0]  tx_err_cnt
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_TXE  = AW'(1);
  localparam logic [AW-1:0] A_RXE  = AW'(2);
  localparam logic [W-1:0]  MAXV   = {W{1'b1}};

  logic [W-1:0] ctrl, rx_q, tx_q;
  logic hold, wr_ctrl, wr_txe;

  assign hold    = ctrl[0];
  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_txe  = reg_wr && reg_addr == A_TXE;

  assign eng_en       = !hold;
  assign tx_force_rec = hold;
  assign rx_err_cnt   = rx_q;
  assign tx_err_cnt   = tx_q;

  function automatic logic [W-1:0] step_cnt(input logic [W-1:0] c,
                                            input logic up, input logic dn,
                                            input logic clr);
    if (clr) return '0;
    if (up && !dn && c != MAXV) return c + 1'b1;
    if (dn && !up && c != '0) return c - 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST;
      rx_q <= '0;
      tx_q <= '0;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata;
      if (hold) begin
        if (wr_txe) begin
          rx_q <= reg_wdata;
          tx_q <= reg_wdata;
        end
      end else begin
        rx_q <= step_cnt(rx_q, rx_inc, rx_dec, cnt_clr);
        tx_q <= step_cnt(tx_q, tx_inc, tx_dec, cnt_clr);
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl;
      A_TXE:   reg_rdata = tx_q;
      A_RXE:   reg_rdata = rx_q;
      default: reg_rdata = '0;
    endcase
  end

  // R2
  a_r2_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (eng_en == !$past(reg_wdata[0])) && (tx_force_rec == $past(reg_wdata[0])));

  // R5
  a_r5_common_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && wr_txe) |=> (rx_err_cnt == $past(reg_wdata)) && (tx_err_cnt == $past(reg_wdata)));

  // R7, R4
  a_r7_frozen_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_txe) |=> $stable(rx_err_cnt) && $stable(tx_err_cnt));

  // R6
  a_r6_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && wr_txe && !rx_inc && !rx_dec && !tx_inc && !tx_dec && !cnt_clr)
      |=> $stable(rx_err_cnt) && $stable(tx_err_cnt));

  // R8
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && tx_inc && !tx_dec && !cnt_clr && tx_err_cnt == MAXV) |=> tx_err_cnt == MAXV);

  // R8
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && rx_dec && !rx_inc && rx_err_cnt == '0) |=> rx_err_cnt == '0);

  // R9
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cnt_clr) |=> (rx_err_cnt == '0) && (tx_err_cnt == '0));
endmodule

// File: tb/sim_can_cfg_regs.sv
`timescale 1ns/1ps
module sim_can_cfg_regs;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic rx_inc = 0, rx_dec = 0, tx_inc = 0, tx_dec = 0, cnt_clr = 0;
  logic eng_en, tx_force_rec;
  logic [7:0] rx_err_cnt, tx_err_cnt;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_ctrl = 8'h07, m_rx = 0, m_tx = 0;

  always #2.5 clk = ~clk;

  can_cfg_regs u0 (.*);

  function automatic logic [7:0] nx(input logic [7:0] c, input logic up, dn, clr);
    if (clr) return 8'h00;
    if (up && !dn) return (c == 8'hFF) ? c : c + 8'd1;
    if (dn && !up) return (c == 8'h00) ? c : c - 8'd1;
    return c;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_tx;
      2'd2: return m_rx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "eng_en", {7'd0, eng_en}, {7'd0, !m_ctrl[0]});
    chk(tag, "tx_force_rec", {7'd0, tx_force_rec}, {7'd0, m_ctrl[0]});
    chk(tag, "rx_err_cnt", rx_err_cnt, m_rx);
    chk(tag, "tx_err_cnt", tx_err_cnt, m_tx);
    chk(tag, "reg_rdata", reg_rdata, exp_rd(reg_addr));
  endtask

  task automatic cyc(input string tag, input logic wr, input logic [1:0] a, input logic [7:0] d,
                     input logic ri, rd, ti, td, cl);
    logic hold;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    rx_inc = ri; rx_dec = rd; tx_inc = ti; tx_dec = td; cnt_clr = cl;
    @(posedge clk);
    hold = m_ctrl[0];
    if (wr && a == 2'd0) m_ctrl = d;
    if (hold) begin
      if (wr && a == 2'd1) begin m_rx = d; m_tx = d; end
    end else begin
      m_rx = nx(m_rx, ri, rd, cl);
      m_tx = nx(m_tx, ti, td, cl);
    end
    @(negedge clk);
    reg_wr = 0; rx_inc = 0; rx_dec = 0; tx_inc = 0; tx_dec = 0; cnt_clr = 0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check_all("R1");
    end
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) cyc("R1", 0, 2'(a), 0, 0, 0, 0, 0, 0);
    // R5: load both while hold, with every strobe active
    cyc("R5", 1, 2'd1, 8'h80, 1, 1, 1, 1, 1);
    // R7: strobes ignored in hold
    cyc("R7", 0, 2'd2, 0, 1, 0, 1, 0, 0);
    cyc("R7", 0, 2'd1, 0, 0, 0, 0, 0, 1);
    // R11: clearing hold with tx_inc in the same cycle
    cyc("R11", 1, 2'd0, 8'h06, 0, 0, 1, 0, 0);
    cyc("R2", 0, 2'd1, 0, 0, 0, 0, 0, 0);
    // R6: load ignored when running
    cyc("R6", 1, 2'd1, 8'h11, 0, 0, 0, 0, 0);
    // R8
    cyc("R8", 0, 2'd1, 0, 0, 0, 1, 0, 0);
    cyc("R8", 0, 2'd2, 0, 0, 1, 0, 0, 0);
    cyc("R8", 0, 2'd1, 0, 1, 1, 1, 1, 0);
    // R9: clear beats inc
    cyc("R9", 0, 2'd2, 0, 1, 0, 1, 0, 1);
    cyc("R8", 0, 2'd2, 0, 0, 1, 0, 1, 0);
    cyc("R8", 0, 2'd1, 0, 0, 0, 1, 0, 0);
    cyc("R8", 0, 2'd2, 0, 1, 0, 1, 0, 0);
    // R4, R3: set hold, counters kept, full byte read back
    cyc("R4", 1, 2'd0, 8'hA5, 0, 0, 0, 0, 0);
    cyc("R3", 0, 2'd0, 0, 0, 0, 0, 0, 0);
    // R8 saturation high
    cyc("R5", 1, 2'd1, 8'hFE, 0, 0, 0, 0, 0);
    cyc("R2", 1, 2'd0, 8'h00, 0, 0, 0, 0, 0);
    cyc("R8", 0, 2'd1, 0, 1, 0, 1, 0, 0);
    cyc("R8", 0, 2'd1, 0, 1, 0, 1, 0, 0);
    cyc("R10", 0, 2'd3, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [1:0] a;
      logic [7:0] d;
      wr = ($urandom % 4) == 0;
      a = 2'($urandom);
      d = 8'($urandom);
      if (a == 2'd0 && ($urandom % 3) != 0) wr = 0;
      if (($urandom % 2) == 0) d = {d[7:1], 1'b0};
      cyc("R10", wr, a, d, ($urandom % 3) == 0, ($urandom % 4) == 0,
          ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 40) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule